// File: doc/BRIEF.md
# Streaming Caesar Letter Shifter

This block rotates ASCII letters through their alphabet, one byte per clock. Each input byte comes with a valid flag and a signed 8-bit rotation amount. A letter moves that many places along its own alphabet and wraps around at the end. An upper-case letter stays within `A`..`Z` and keeps its case. A lower-case letter stays within `a`..`z`. Every byte that is not a letter leaves the block unchanged.

A build-time parameter sets the direction of the rotation. With the parameter set to forward, the amount is added. With it set to reverse, the amount is subtracted. Two instances with opposite settings and the same amount therefore undo each other.

The rotation amount may be any signed byte. The block first reduces it to an equivalent step of 0..25. It then applies one 8-bit add and at most one correction of 26, so no wide modulo sits on the character path. The result leaves through a single output register, one cycle after the input.

Top module: `letter_rotor`

## Requirements
- R1: Any byte outside 0x41..0x5A and 0x61..0x7A is output unchanged, whatever the rotation amount.
- R2: An upper-case letter (0x41..0x5A) is rotated within 0x41..0x5A and wraps from the top back to the bottom; for example, "ABCXYZ" rotated forward by 3 gives "DEFABC".
- R3: A lower-case letter (0x61..0x7A) is rotated within 0x61..0x7A. The range compare is unsigned, so `z` rotated forward by 25 gives `y`.
- R4: With parameter FORWARD=1 the output is (position + amount) mod 26 within the letter's alphabet. With FORWARD=0 it is (position − amount) mod 26.
- R5: The amount is a signed two's-complement byte. Amounts outside −25..25 act as their value modulo 26: 27 acts as 1, −1 moves one place back, and −128 acts as −24.
- R6: out_valid equals in_valid of the previous clock cycle.
- R7: out_char loads only in a cycle with in_valid high and keeps its value otherwise.
- R8: A synchronous active-high reset sets out_valid and out_char to 0.
- R9: A forward instance followed by a reverse instance with the same amount returns the original byte, for every one of the 256 bytes combined with every one of the 256 amounts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present this cycle |
| in_char | input | 8 | Input byte |
| in_shift | input | 8 | Signed rotation amount for this byte |
| out_valid | output | 1 | Output byte is present |
| out_char | output | 8 | Rotated or passed-through byte |

## Verification
Two functions can act on the same byte in one cycle: the reduction of an out-of-range signed amount, and the wrap correction at the end of an alphabet. Both act together when a letter near `Z` or `z` arrives with an amount such as 127, −1 or −128. The directed vectors provoke this case, and so does a sweep of all 65,536 byte and amount pairs driven back to back. A scoreboard compares each output with a modulo-26 position model. The same stream also passes through a second instance set to reverse, and every byte that comes back must equal the byte sent.

// File: rtl/rotor_pkg.sv
package rotor_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] ch;
    } rotor_state_t;

endpackage

// File: rtl/rotor_key_reduce.sv
module rotor_key_reduce #(
    parameter int CHAR_W    = 8,
    parameter int ALPHA_LEN = 26,
    parameter bit FORWARD   = 1'b1
) (
    input  logic signed [CHAR_W-1:0] shift_i,
    output logic        [CHAR_W-1:0] step_o
);
    localparam int EXT_W = CHAR_W + 1;
    localparam logic signed [EXT_W-1:0] LEN_S = EXT_W'(ALPHA_LEN);

    logic signed [EXT_W-1:0] wide_s;
    logic signed [EXT_W-1:0] rem_s;
    logic signed [EXT_W-1:0] norm_s;

    always_comb begin
        wide_s = {shift_i[CHAR_W-1], shift_i};
        rem_s  = wide_s % LEN_S;
        norm_s = (rem_s < 0) ? rem_s + LEN_S : rem_s;
    end

    generate
        if (FORWARD) begin : g_fwd
            assign step_o = norm_s[CHAR_W-1:0];
        end else begin : g_rev
            logic signed [EXT_W-1:0] comp_s;
            assign comp_s = (norm_s == '0) ? '0 : LEN_S - norm_s;
            assign step_o = comp_s[CHAR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/rotor_char_map.sv
module rotor_char_map #(
    parameter int CHAR_W    = 8,
    parameter int ALPHA_LEN = 26
) (
    input  logic [CHAR_W-1:0] ch_i,
    input  logic [CHAR_W-1:0] step_i,
    output logic [CHAR_W-1:0] ch_o
);
    localparam logic [CHAR_W-1:0] UP_FIRST = CHAR_W'(8'h41);
    localparam logic [CHAR_W-1:0] UP_LAST  = CHAR_W'(8'h5A);
    localparam logic [CHAR_W-1:0] LO_FIRST = CHAR_W'(8'h61);
    localparam logic [CHAR_W-1:0] LO_LAST  = CHAR_W'(8'h7A);
    localparam logic [CHAR_W-1:0] LEN_U    = CHAR_W'(ALPHA_LEN);

    logic              is_up;
    logic              is_lo;
    logic [CHAR_W-1:0] base;
    logic [CHAR_W-1:0] sum;
    logic [CHAR_W-1:0] folded;

    always_comb begin
        is_up  = (ch_i >= UP_FIRST) && (ch_i <= UP_LAST);
        is_lo  = (ch_i >= LO_FIRST) && (ch_i <= LO_LAST);
        base   = is_up ? UP_FIRST : LO_FIRST;
        sum    = ch_i + step_i;
        folded = sum - LEN_U;
        if (!(is_up || is_lo)) begin
            ch_o = ch_i;
        end else if (folded >= base) begin
            ch_o = folded;
        end else begin
            ch_o = sum;
        end
    end

endmodule

// File: rtl/letter_rotor.sv
module letter_rotor #(
    parameter int CHAR_W    = 8,
    parameter int ALPHA_LEN = 26,
    parameter bit FORWARD   = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic        [CHAR_W-1:0] in_char,
    input  logic signed [CHAR_W-1:0] in_shift,
    output logic                     out_valid,
    output logic        [CHAR_W-1:0] out_char
);
    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] ch;
    } stage_t;

    logic [CHAR_W-1:0] step;
    logic [CHAR_W-1:0] mapped;
    stage_t            stage_d;
    stage_t            stage_q;

    rotor_key_reduce #(
        .CHAR_W    (CHAR_W),
        .ALPHA_LEN (ALPHA_LEN),
        .FORWARD   (FORWARD)
    ) i_key (
        .shift_i (in_shift),
        .step_o  (step)
    );

    rotor_char_map #(
        .CHAR_W    (CHAR_W),
        .ALPHA_LEN (ALPHA_LEN)
    ) i_map (
        .ch_i   (in_char),
        .step_i (step),
        .ch_o   (mapped)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.ch = mapped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign out_char  = stage_q.ch;

endmodule

// File: rtl/letter_rotor_chk.sv
module letter_rotor_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [CHAR_W-1:0] in_char,
    input logic              out_valid,
    input logic [CHAR_W-1:0] out_char
);
    function automatic logic upper_f(input logic [CHAR_W-1:0] c);
        return (c > CHAR_W'(8'h40)) && (c < CHAR_W'(8'h5B));
    endfunction

    function automatic logic lower_f(input logic [CHAR_W-1:0] c);
        return (c > CHAR_W'(8'h60)) && (c < CHAR_W'(8'h7B));
    endfunction

    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_char));

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !upper_f(in_char) && !lower_f(in_char)) |=> (out_char == $past(in_char)));

    // R2
    upper_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && upper_f(in_char)) |=> upper_f(out_char));

    // R3
    lower_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lower_f(in_char)) |=> lower_f(out_char));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_char == '0));

endmodule

bind letter_rotor letter_rotor_chk #(.CHAR_W(CHAR_W)) i_letter_rotor_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_char   (in_char),
    .out_valid (out_valid),
    .out_char  (out_char)
);

// File: tb/test_letter_rotor.sv
module test_letter_rotor;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        in_char = 8'h00;
    logic signed [7:0] in_shift = 8'sh00;
    logic              out_valid;
    logic [7:0]        out_char;
    logic signed [7:0] shift_dly = 8'sh00;
    logic              back_valid;
    logic [7:0]        back_char;

    int  n_vec  = 0;
    int  n_miss = 0;
    bit  done   = 1'b0;

    logic [7:0] q_exp[$];
    string      q_tag[$];
    logic [7:0] q_orig[$];

    always #5 clk = ~clk;

    letter_rotor #(.FORWARD(1'b1)) i_letter_rotor (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_char   (in_char),
        .in_shift  (in_shift),
        .out_valid (out_valid),
        .out_char  (out_char)
    );

    always @(posedge clk) shift_dly <= in_shift;

    letter_rotor #(.FORWARD(1'b0)) i_letter_rotor_rev (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (out_valid),
        .in_char   (out_char),
        .in_shift  (shift_dly),
        .out_valid (back_valid),
        .out_char  (back_char)
    );

    function automatic logic [7:0] model(input logic [7:0] c, input logic signed [7:0] s,
                                         input bit fwd);
        int k;
        int base;
        int p;
        k = int'(s) % 26;
        if (!fwd) k = -k;
        if (c >= 8'd65 && c <= 8'd90) base = 65;
        else if (c >= 8'd97 && c <= 8'd122) base = 97;
        else return c;
        p = (int'(c) - base + k) % 26;
        if (p < 0) p = p + 26;
        return 8'(base + p);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] c, input logic signed [7:0] s, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = c;
        in_shift = s;
        q_exp.push_back(model(c, s, 1'b1));
        q_tag.push_back(tag);
        q_orig.push_back(c);
    endtask

    task automatic drive_str(input string str, input logic signed [7:0] s, input string tag);
        for (int i = 0; i < str.len(); i++) drive(str[i], s, tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R6 unexpected out_valid", out_char, 8'h00);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check(out_char === e, t, out_char, e);
                end
            end
            if (back_valid) begin
                if (q_orig.size() == 0) begin
                    check(1'b0, "R9 unexpected return", back_char, 8'h00);
                end else begin
                    logic [7:0] o;
                    o = q_orig.pop_front();
                    check(back_char === o, "R9 round trip", back_char, o);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_miss++;
            n_vec++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check(out_valid === 1'b0, "R8 out_valid in reset", {7'd0, out_valid}, 8'h00);
        check(out_char === 8'h00, "R8 out_char in reset", out_char, 8'h00);
        rst = 1'b0;

        drive_str("ABCXYZ", 8'sd3, "R2 upper wrap");
        drive_str("Zz", 8'sd1, "R2 R3 end wrap");
        drive_str("xyz", 8'sd25, "R3 unsigned lower");
        drive_str("@[`{09 ~", 8'sd5, "R1 non-letter");
        drive(8'hFF, -8'sd7, "R1 high byte");
        drive(8'h80, 8'sd127, "R1 high byte");
        drive_str("aZm", 8'sd27, "R5 amount 27");
        drive_str("aA", -8'sd1, "R5 amount -1");
        drive_str("zZ", -8'sd128, "R5 amount -128");
        drive_str("yB", 8'sd127, "R5 amount 127");
        drive_str("Hello", 8'sd13, "R4 forward add");

        // R6/R7: idle cycles must not change out_char
        drive("A", 8'sd1, "R2 single");
        @(negedge clk);
        in_valid = 1'b0;
        in_char  = "Q";
        in_shift = 8'sd9;
        @(negedge clk);
        check(out_valid === 1'b0, "R6 idle out_valid", {7'd0, out_valid}, 8'h00);
        check(out_char === "B", "R7 hold on idle", out_char, "B");
        @(negedge clk);
        check(out_char === "B", "R7 hold second idle", out_char, "B");

        // full sweep for R4 and R9
        for (int c = 0; c < 256; c++) begin
            for (int s = -128; s < 128; s++) begin
                drive(8'(c), 8'(s), "R4 sweep");
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(q_exp.size() == 0, "R6 forward drained", 8'(q_exp.size()), 8'h00);
        check(q_orig.size() == 0, "R9 reverse drained", 8'(q_orig.size()), 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule